// File: doc/BRIEF.md
# Nibble ALU with Carry and Status Flags

This block is the arithmetic and logic core of a small 4-bit controller. Each cycle it takes an operation code, an accumulator value, a second operand (from memory or a register), a 4-bit immediate and a bit index. It returns the combinational result together with the next carry flag (CF) and the next status flag (SF). Two flag registers take those next values at every rising clock edge. The stored CF then feeds the carry-consuming operations in the following cycle.

The status flag has no single meaning. Its rule depends on the operation: the inverse of the carry out, the carry itself, a nonzero result, the inverse of a tested bit, a copy of CF, or a forced 1. Only add-with-carry, reverse subtract and the carry set/clear operations write CF. Reverse subtract computes operand minus accumulator minus the inverted carry, so CF=1 means no borrow.

There is no data stream here. Every pin is a plain control or data pin with no valid/ready handshake, and an operation is taken on every cycle. Opcodes that the block does not define leave both flags unchanged.

Top module: `nib_alu_core`

## Requirements
- R1: Opcode 2 gives acc+opd and opcode 3 gives acc+imm, both modulo 16. SF_next is the inverse of the 5th sum bit, and CF is unchanged.
- R2: Opcode 4 gives acc+opd+CF modulo 16. CF_next is the carry out and SF_next is its inverse.
- R3: Opcode 5 gives opd-acc-(1-CF) modulo 16. CF_next is 1 when that difference is not negative, and SF_next equals CF_next.
- R4: Opcode 6 gives opd+1 with SF_next = 1 unless opd is 15. Opcode 7 gives opd-1 with SF_next = 1 unless opd is 0. Neither opcode changes CF.
- R5: Opcodes 8, 9 and 10 give acc AND, OR and XOR opd. SF_next is 1 exactly when the result is nonzero, and CF is unchanged.
- R6: Opcode 11 clears bit bit_sel of opd and opcode 12 sets it. Both set SF_next to 1 and leave CF unchanged.
- R7: Opcode 13 returns opd unaltered and sets SF_next to the inverse of bit bit_sel of opd. CF is unchanged.
- R8: Opcode 14 sets CF and opcode 15 clears CF. Both force SF_next to 1 and return acc.
- R9: Opcode 16 copies the stored CF into SF_next, leaves CF unchanged and returns acc.
- R10: Opcode 0 returns opd and opcode 1 returns imm. Both set SF_next to 1 and leave CF unchanged.
- R11: Opcodes 17 to 31 return acc and hold both flags at their stored values.
- R12: At every rising clock edge, cf_o and sf_o take cf_next_o and sf_next_o. An asynchronous active-low reset gives CF=0 and SF=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the flag registers |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_i | input | 5 | Operation code |
| acc_i | input | 4 | Accumulator operand |
| opd_i | input | 4 | Memory or register operand |
| imm_i | input | 4 | Immediate operand |
| bit_sel_i | input | 2 | Bit index for bit operations |
| res_o | output | 4 | Combinational result |
| cf_next_o | output | 1 | Carry flag value for the next cycle |
| sf_next_o | output | 1 | Status flag value for the next cycle |
| cf_o | output | 1 | Stored carry flag |
| sf_o | output | 1 | Stored status flag |

## Verification
The only internal state is the two flag registers. A wrong CF shows up in the very next cycle: add-with-carry or reverse subtract gives a result off by one, or a carry test gives the wrong SF_next. A wrong SF is visible directly on sf_o one edge after the operation that produced it. For this reason every sweep vector first forces CF with a carry set or clear, then runs the operation, and then checks the stored flags one edge later.

// File: rtl/nib_alu_pkg.sv
package nib_alu_pkg;
  localparam int OP_W = 5;

  typedef enum logic [OP_W-1:0] {
    OP_LDM  = 5'd0,  OP_LDI  = 5'd1,  OP_ADDM = 5'd2,  OP_ADDI = 5'd3,
    OP_ADDC = 5'd4,  OP_SUBR = 5'd5,  OP_INC  = 5'd6,  OP_DEC  = 5'd7,
    OP_AND  = 5'd8,  OP_OR   = 5'd9,  OP_XOR  = 5'd10, OP_BCLR = 5'd11,
    OP_BSET = 5'd12, OP_BTST = 5'd13, OP_CSET = 5'd14, OP_CCLR = 5'd15,
    OP_CTST = 5'd16
  } alu_op_e;

  typedef enum logic [2:0] {RS_ACC, RS_OPD, RS_IMM, RS_ARITH, RS_LOGIC} res_src_e;
  typedef enum logic [2:0] {AK_ADDM, AK_ADDI, AK_ADDC, AK_SUBR, AK_INC, AK_DEC} arith_kind_e;
  typedef enum logic [2:0] {SR_HOLD, SR_ONE, SR_NCARRY, SR_CARRY, SR_NZERO, SR_NBIT, SR_CF} sf_rule_e;
  typedef enum logic [1:0] {CR_HOLD, CR_CARRY, CR_SET, CR_CLR} cf_rule_e;

  typedef struct packed {
    res_src_e    src;
    arith_kind_e kind;
    sf_rule_e    sf_rule;
    cf_rule_e    cf_rule;
  } ctrl_t;
endpackage

// File: rtl/nib_alu_decode.sv
module nib_alu_decode
  import nib_alu_pkg::*;
(
  input  logic [OP_W-1:0] op_i,
  output ctrl_t           ctrl_o
);
  alu_op_e op;
  assign op = alu_op_e'(op_i);

  always_comb begin
    ctrl_o = '{src: RS_ACC, kind: AK_ADDM, sf_rule: SR_HOLD, cf_rule: CR_HOLD};
    case (op)
      OP_LDM:  begin ctrl_o.src = RS_OPD; ctrl_o.sf_rule = SR_ONE; end
      OP_LDI:  begin ctrl_o.src = RS_IMM; ctrl_o.sf_rule = SR_ONE; end
      OP_ADDM: begin ctrl_o.src = RS_ARITH; ctrl_o.kind = AK_ADDM; ctrl_o.sf_rule = SR_NCARRY; end
      OP_ADDI: begin ctrl_o.src = RS_ARITH; ctrl_o.kind = AK_ADDI; ctrl_o.sf_rule = SR_NCARRY; end
      OP_ADDC: begin
        ctrl_o.src = RS_ARITH; ctrl_o.kind = AK_ADDC;
        ctrl_o.sf_rule = SR_NCARRY; ctrl_o.cf_rule = CR_CARRY;
      end
      OP_SUBR: begin
        ctrl_o.src = RS_ARITH; ctrl_o.kind = AK_SUBR;
        ctrl_o.sf_rule = SR_CARRY; ctrl_o.cf_rule = CR_CARRY;
      end
      OP_INC:  begin ctrl_o.src = RS_ARITH; ctrl_o.kind = AK_INC; ctrl_o.sf_rule = SR_NCARRY; end
      OP_DEC:  begin ctrl_o.src = RS_ARITH; ctrl_o.kind = AK_DEC; ctrl_o.sf_rule = SR_CARRY; end
      OP_AND, OP_OR, OP_XOR: begin ctrl_o.src = RS_LOGIC; ctrl_o.sf_rule = SR_NZERO; end
      OP_BCLR, OP_BSET: begin ctrl_o.src = RS_LOGIC; ctrl_o.sf_rule = SR_ONE; end
      OP_BTST: begin ctrl_o.src = RS_OPD; ctrl_o.sf_rule = SR_NBIT; end
      OP_CSET: begin ctrl_o.sf_rule = SR_ONE; ctrl_o.cf_rule = CR_SET; end
      OP_CCLR: begin ctrl_o.sf_rule = SR_ONE; ctrl_o.cf_rule = CR_CLR; end
      OP_CTST: ctrl_o.sf_rule = SR_CF;
      default: ;
    endcase
  end
endmodule

// File: rtl/nib_alu_arith.sv
module nib_alu_arith
  import nib_alu_pkg::*;
#(
  parameter int DATA_W = 4
) (
  input  arith_kind_e       kind_i,
  input  logic [DATA_W-1:0] acc_i,
  input  logic [DATA_W-1:0] opd_i,
  input  logic [DATA_W-1:0] imm_i,
  input  logic              cf_i,
  output logic [DATA_W-1:0] sum_o,
  output logic              carry_o
);
  logic [DATA_W-1:0] a_in, b_in;
  logic              c_in;
  logic [DATA_W:0]   full;

  // One shared adder; subtract and decrement use two's complement forms.
  always_comb begin
    a_in = acc_i; b_in = opd_i; c_in = 1'b0;
    case (kind_i)
      AK_ADDI: b_in = imm_i;
      AK_ADDC: c_in = cf_i;
      AK_SUBR: begin a_in = opd_i; b_in = ~acc_i; c_in = cf_i; end
      AK_INC:  begin a_in = opd_i; b_in = '0; c_in = 1'b1; end
      AK_DEC:  begin a_in = opd_i; b_in = '1; end
      default: ;
    endcase
  end

  assign full    = {1'b0, a_in} + {1'b0, b_in} + {{DATA_W{1'b0}}, c_in};
  assign sum_o   = full[DATA_W-1:0];
  assign carry_o = full[DATA_W];
endmodule

// File: rtl/nib_alu_bitlogic.sv
module nib_alu_bitlogic
  import nib_alu_pkg::*;
#(
  parameter int DATA_W = 4,
  localparam int IDX_W = $clog2(DATA_W)
) (
  input  logic [OP_W-1:0]   op_i,
  input  logic [DATA_W-1:0] acc_i,
  input  logic [DATA_W-1:0] opd_i,
  input  logic [IDX_W-1:0]  bit_sel_i,
  output logic [DATA_W-1:0] res_o,
  output logic              bit_o
);
  logic [DATA_W-1:0] mask;

  for (genvar g = 0; g < DATA_W; g++) begin : g_mask
    assign mask[g] = (bit_sel_i == IDX_W'(g));
  end

  assign bit_o = |(opd_i & mask);

  always_comb begin
    case (alu_op_e'(op_i))
      OP_AND:  res_o = acc_i & opd_i;
      OP_OR:   res_o = acc_i | opd_i;
      OP_XOR:  res_o = acc_i ^ opd_i;
      OP_BCLR: res_o = opd_i & ~mask;
      OP_BSET: res_o = opd_i | mask;
      default: res_o = opd_i;
    endcase
  end
endmodule

// File: rtl/nib_alu_core.sv
module nib_alu_core
  import nib_alu_pkg::*;
#(
  parameter int DATA_W = 4,
  localparam int IDX_W = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [OP_W-1:0]   op_i,
  input  logic [DATA_W-1:0] acc_i,
  input  logic [DATA_W-1:0] opd_i,
  input  logic [DATA_W-1:0] imm_i,
  input  logic [IDX_W-1:0]  bit_sel_i,
  output logic [DATA_W-1:0] res_o,
  output logic              cf_next_o,
  output logic              sf_next_o,
  output logic              cf_o,
  output logic              sf_o
);
  ctrl_t             ctrl;
  logic [DATA_W-1:0] arith_res, logic_res;
  logic              carry, tbit;
  logic              cf_q, sf_q;

  nib_alu_decode u_dec (.op_i(op_i), .ctrl_o(ctrl));

  nib_alu_arith #(.DATA_W(DATA_W)) u_arith (
    .kind_i(ctrl.kind), .acc_i(acc_i), .opd_i(opd_i), .imm_i(imm_i),
    .cf_i(cf_q), .sum_o(arith_res), .carry_o(carry)
  );

  nib_alu_bitlogic #(.DATA_W(DATA_W)) u_logic (
    .op_i(op_i), .acc_i(acc_i), .opd_i(opd_i), .bit_sel_i(bit_sel_i),
    .res_o(logic_res), .bit_o(tbit)
  );

  always_comb begin
    case (ctrl.src)
      RS_OPD:   res_o = opd_i;
      RS_IMM:   res_o = imm_i;
      RS_ARITH: res_o = arith_res;
      RS_LOGIC: res_o = logic_res;
      default:  res_o = acc_i;
    endcase
  end

  always_comb begin
    case (ctrl.cf_rule)
      CR_CARRY: cf_next_o = carry;
      CR_SET:   cf_next_o = 1'b1;
      CR_CLR:   cf_next_o = 1'b0;
      default:  cf_next_o = cf_q;
    endcase
    case (ctrl.sf_rule)
      SR_ONE:    sf_next_o = 1'b1;
      SR_NCARRY: sf_next_o = ~carry;
      SR_CARRY:  sf_next_o = carry;
      SR_NZERO:  sf_next_o = |logic_res;
      SR_NBIT:   sf_next_o = ~tbit;
      SR_CF:     sf_next_o = cf_q;
      default:   sf_next_o = sf_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cf_q <= 1'b0;
      sf_q <= 1'b1;
    end else begin
      cf_q <= cf_next_o;
      sf_q <= sf_next_o;
    end
  end

  assign cf_o = cf_q;
  assign sf_o = sf_q;
endmodule

// File: rtl/nib_alu_chk.sv
module nib_alu_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [4:0] op_i,
  input logic [3:0] opd_i,
  input logic [1:0] bit_sel_i,
  input logic [3:0] res_o,
  input logic       cf_next_o,
  input logic       sf_next_o,
  input logic       cf_o,
  input logic       sf_o
);
  p_reset_value_r12: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (sf_o && !cf_o));

  p_regs_follow_r12: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (cf_o == $past(cf_next_o) && sf_o == $past(sf_next_o)));

  p_logic_nonzero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i inside {5'd8, 5'd9, 5'd10}) |-> (sf_next_o == (res_o != 4'd0) && cf_next_o == cf_o));

  p_bit_test_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i == 5'd13) |-> (sf_next_o == !opd_i[bit_sel_i] && res_o == opd_i));

  p_carry_test_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i == 5'd16) |-> (sf_next_o == cf_o && cf_next_o == cf_o));

  p_carry_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i == 5'd14) |-> (cf_next_o && sf_next_o));

  p_undefined_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i > 5'd16) |-> (cf_next_o == cf_o && sf_next_o == sf_o));
endmodule

bind nib_alu_core nib_alu_chk u_chk (
  .clk(clk), .rst_n(rst_n), .op_i(op_i), .opd_i(opd_i), .bit_sel_i(bit_sel_i),
  .res_o(res_o), .cf_next_o(cf_next_o), .sf_next_o(sf_next_o),
  .cf_o(cf_o), .sf_o(sf_o)
);

// File: tb/tb_nib_alu_core.sv
module tb_nib_alu_core;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [4:0] op_i = '0;
  logic [3:0] acc_i = '0, opd_i = '0, imm_i = '0;
  logic [1:0] bit_sel_i = '0;
  logic [3:0] res_o;
  logic       cf_next_o, sf_next_o, cf_o, sf_o;

  int n_chk = 0, n_bad = 0, cycles = 0;

  always #4 clk = ~clk;

  nib_alu_core dut (
    .clk(clk), .rst_n(rst_n), .op_i(op_i), .acc_i(acc_i), .opd_i(opd_i),
    .imm_i(imm_i), .bit_sel_i(bit_sel_i), .res_o(res_o),
    .cf_next_o(cf_next_o), .sf_next_o(sf_next_o), .cf_o(cf_o), .sf_o(sf_o)
  );

  function automatic string req_of(int op);
    if (op == 2 || op == 3) return "R1";
    if (op == 4) return "R2";
    if (op == 5) return "R3";
    if (op == 6 || op == 7) return "R4";
    if (op >= 8 && op <= 10) return "R5";
    if (op == 11 || op == 12) return "R6";
    if (op == 13) return "R7";
    if (op == 14 || op == 15) return "R8";
    if (op == 16) return "R9";
    if (op <= 1) return "R10";
    return "R11";
  endfunction

  // Reference model from the requirements; returns {res, cf, sf}.
  function automatic logic [5:0] model(int op, int a, int m, int k, int b, bit cf, bit sf);
    int r = a, t;
    bit c = cf, s = sf;
    case (op)
      0: begin r = m; s = 1; end
      1: begin r = k; s = 1; end
      2: begin t = a + m; r = t % 16; s = (t < 16); end
      3: begin t = a + k; r = t % 16; s = (t < 16); end
      4: begin t = a + m + cf; r = t % 16; c = (t >= 16); s = !c; end
      5: begin t = m - a - (cf ? 0 : 1); r = (t + 32) % 16; c = (t >= 0); s = c; end
      6: begin r = (m + 1) % 16; s = (m != 15); end
      7: begin r = (m + 15) % 16; s = (m != 0); end
      8: begin r = a & m; s = (r != 0); end
      9: begin r = a | m; s = (r != 0); end
      10: begin r = a ^ m; s = (r != 0); end
      11: begin r = m & ~(1 << b) & 15; s = 1; end
      12: begin r = m | (1 << b); s = 1; end
      13: begin r = m; s = !((m >> b) & 1); end
      14: begin c = 1; s = 1; end
      15: begin c = 0; s = 1; end
      16: s = cf;
      default: ;
    endcase
    return {r[3:0], c, s};
  endfunction

  task automatic compare(string req, string what, logic [5:0] act, logic [5:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic run_vec(int op, int a, int m, int k, int b, bit cf);
    logic [5:0] e;
    @(negedge clk);
    op_i = cf ? 5'd14 : 5'd15;
    @(negedge clk);
    op_i = 5'(op); acc_i = 4'(a); opd_i = 4'(m); imm_i = 4'(k); bit_sel_i = 2'(b);
    #1;
    e = model(op, a, m, k, b, cf, 1'b1);
    compare(req_of(op), "comb res/cf/sf", {res_o, cf_next_o, sf_next_o}, e);
    @(posedge clk);
    #1;
    compare("R12", "stored cf/sf", {4'd0, cf_o, sf_o}, {4'd0, e[1:0]});
  endtask

  initial begin : watchdog
    while (cycles < 200000) begin
      @(posedge clk);
      cycles++;
    end
    n_bad++;
    $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #20;
    compare("R12", "reset flags", {4'd0, cf_o, sf_o}, 6'b000001);
    @(negedge clk);
    rst_n = 1'b1;
    // Undefined opcode right after reset: flags stay at reset values (R11).
    op_i = 5'd20;
    @(posedge clk);
    #1;
    compare("R11", "hold after reset", {4'd0, cf_o, sf_o}, 6'b000001);
    for (int op = 0; op < 32; op++)
      for (int a = 0; a < 16; a++)
        for (int m = 0; m < 16; m++)
          for (int cf = 0; cf < 2; cf++) begin
            if (op >= 11 && op <= 13)
              for (int b = 0; b < 4; b++) run_vec(op, a, m, m ^ 5, b, cf[0]);
            else
              run_vec(op, a, m, (m ^ 5) + a & 15, a & 3, cf[0]);
          end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule